// File: doc/BRIEF.md
# Paged-Address Bus DMA Sequencer

This block borrows an 8-bit CPU memory bus and moves a block of bytes between a host port and memory. It asks for the bus with an active-low bus request. It waits for the active-low grant, then runs one memory cycle per byte using active-low memory-request, read and write strobes. When the last byte is done it floats its outputs, drops the request and raises a done flag.

The low address byte and the data byte come straight from the block and change on every access. The high address byte is loaded into a slow external register through a request/done handshake, and that link can take any number of cycles. The block loads the high byte once before the first access. After that it reloads it only when the low byte rolls over from FF to 00. The cost of the slow link is therefore paid once per 256-byte page and not once per byte.

On a write transfer, the host supplies bytes through a valid/ready pair. On a read transfer, each byte comes back with a one-cycle valid pulse.

Top module: `dma_bus_seq`

## Requirements
- R1: A start with a length of zero raises done on the next cycle and never drives busrq_n low.
- R2: No strobe and no output enable is asserted until busrq_n is low and busack_n has been returned low.
- R3: hi_req is raised before the first access and again after every access whose low address byte was FF. It stays high with hi_byte steady until hi_done is seen, and no strobe is asserted while it is high. The number of updates equals the number of 256-byte pages touched.
- R4: Access k of a transfer (k from 0) uses address start+k modulo 65536, with the low byte on addr_lo, and the transfer makes exactly length accesses.
- R5: A write takes its bytes in order through the wr_valid/wr_ready handshake. It drives data_out with data_oe high for at least one cycle before mreq_n and wr_n go low, and keeps mreq_n and wr_n low for STROBE_W cycles.
- R6: A read samples data_in in the last strobe cycle. It presents that byte on rd_data with rd_valid high for exactly the one cycle after the strobe, giving length pulses in address order.
- R7: rd_n and wr_n are never low together or without mreq_n. addr_lo is steady while mreq_n is low, and mreq_n is high for at least one cycle between accesses.
- R8: bus_oe and data_oe are low for at least one cycle before busrq_n returns high. done rises as busrq_n returns high and stays high until the next start.
- R9: After reset, busrq_n, mreq_n, rd_n and wr_n are high, and bus_oe, data_oe, hi_req, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| cfg_addr | input | 16 | First memory address |
| cfg_len | input | LEN_W | Number of bytes |
| cfg_write | input | 1 | 1 = host to memory, 0 = memory to host |
| wr_data | input | 8 | Host byte for writes |
| wr_valid | input | 1 | Host byte available |
| wr_ready | output | 1 | Block takes wr_data this cycle |
| rd_data | output | 8 | Byte read from memory |
| rd_valid | output | 1 | rd_data valid (one-cycle pulse) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| busrq_n | output | 1 | Bus request, active low |
| busack_n | input | 1 | Bus grant, active low |
| bus_oe | output | 1 | Enable for addr_lo and the strobes |
| addr_lo | output | 8 | Low address byte |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| data_oe | output | 1 | Enable for data_out |
| data_out | output | 8 | Data driven during writes |
| data_in | input | 8 | Data bus as seen by the block |
| hi_req | output | 1 | Request to load hi_byte into the slow register |
| hi_byte | output | 8 | High address byte to load |
| hi_done | input | 1 | Slow register load finished |

## Verification
The bench builds the block with STROBE_W set to 3, so each strobe lasts several cycles and its width can be measured. LEN_W is set to 10, which allows transfers of a few hundred bytes against a 1 KiB memory model addressed through the modelled high-byte register. It sweeps every start offset from four bytes below a page end to a page start, against lengths 1 to 6 and three high-byte link latencies. This puts each page-crossing position under both directions. A 300-byte transfer touches three pages, and a zero-length start exercises the immediate completion.

// File: rtl/dma_bus_seq.sv
module dma_bus_seq #(
  parameter int LEN_W    = 16,
  parameter int STROBE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      cfg_addr,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_write,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             busrq_n,
  input  logic             busack_n,
  output logic             bus_oe,
  output logic [7:0]       addr_lo,
  output logic             mreq_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             data_oe,
  output logic [7:0]       data_out,
  input  logic [7:0]       data_in,
  output logic             hi_req,
  output logic [7:0]       hi_byte,
  input  logic             hi_done
);
  localparam int CW = $clog2(STROBE_W) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_HI, S_SETUP, S_PREP, S_STRB, S_HOLD, S_REL
  } st_t;

  st_t             st;
  logic [15:0]     addr;
  logic [LEN_W-1:0] remain;
  logic            is_wr;
  logic [7:0]      wdat;
  logic [CW-1:0]   scnt;

  assign busy     = st != S_IDLE;
  assign wr_ready = st == S_SETUP && is_wr;
  assign hi_req   = st == S_HI;
  assign hi_byte  = addr[15:8];
  assign addr_lo  = addr[7:0];
  assign bus_oe   = st inside {S_HI, S_SETUP, S_PREP, S_STRB, S_HOLD};
  assign data_oe  = is_wr && st inside {S_PREP, S_STRB, S_HOLD};
  assign data_out = wdat;
  assign mreq_n   = st != S_STRB;
  assign rd_n     = !(st == S_STRB && !is_wr);
  assign wr_n     = !(st == S_STRB && is_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr     <= '0;
      remain   <= '0;
      is_wr    <= 1'b0;
      wdat     <= '0;
      scnt     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      busrq_n  <= 1'b1;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr   <= cfg_addr;
          remain <= cfg_len;
          is_wr  <= cfg_write;
          if (cfg_len == '0) begin
            done <= 1'b1;
          end else begin
            done    <= 1'b0;
            busrq_n <= 1'b0;
            st      <= S_REQ;
          end
        end
        S_REQ: if (!busack_n) st <= S_HI;
        S_HI:  if (hi_done) st <= S_SETUP;
        S_SETUP: begin
          if (!is_wr) st <= S_PREP;
          else if (wr_valid) begin
            wdat <= wr_data;
            st   <= S_PREP;
          end
        end
        S_PREP: begin
          scnt <= CW'(STROBE_W - 1);
          st   <= S_STRB;
        end
        S_STRB: begin
          if (scnt == '0) begin
            if (!is_wr) begin
              rd_data  <= data_in;
              rd_valid <= 1'b1;
            end
            st <= S_HOLD;
          end else begin
            scnt <= scnt - 1'b1;
          end
        end
        S_HOLD: begin
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) begin
            st <= S_REL;
          end else begin
            addr <= addr + 16'd1;
            st   <= (addr[7:0] == 8'hFF) ? S_HI : S_SETUP;
          end
        end
        S_REL: begin
          busrq_n <= 1'b1;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_bus_seq_chk.sv
module dma_bus_seq_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] cfg_len,
  input logic             busy,
  input logic             done,
  input logic             busrq_n,
  input logic             busack_n,
  input logic             bus_oe,
  input logic [7:0]       addr_lo,
  input logic             mreq_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             data_oe,
  input logic [7:0]       data_out,
  input logic             rd_valid,
  input logic             hi_req,
  input logic [7:0]       hi_byte,
  input logic             hi_done
);
  AST_ZERO_LEN_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_len == '0) |=> (done && busrq_n)); // R1
  AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n || bus_oe) |-> (!busrq_n && !busack_n)); // R2
  AST_HI_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    hi_req |-> mreq_n); // R3
  AST_HI_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_req && !hi_done) |=> (hi_req && $stable(hi_byte))); // R3
  AST_WDATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ($past(data_oe) && $stable(data_out))); // R5
  AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!rd_n) && rd_n)); // R6
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (!mreq_n && (rd_n || wr_n))); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && $past(!mreq_n)) |-> $stable(addr_lo)); // R7
  AST_FLOAT_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busrq_n) |-> (!bus_oe && !data_oe && $past(!bus_oe) && done)); // R8
endmodule

bind dma_bus_seq dma_bus_seq_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/dma_bus_seq_tb_top.sv
module dma_bus_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 10;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0, start = 0, cfg_write = 0;
  logic [15:0] cfg_addr = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [7:0] wr_data, rd_data, addr_lo, data_out, data_in, hi_byte;
  logic wr_valid = 1, wr_ready, rd_valid, busy, done, busrq_n, busack_n;
  logic bus_oe, mreq_n, rd_n, wr_n, data_oe, hi_req, hi_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_bus_seq #(.LEN_W(LEN_W), .STROBE_W(SW)) dut_i (.*);

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int s, int k);
    return 8'((s * 7 + k * 13 + (k >> 3)) & 255);
  endfunction

  logic [7:0] mem [1024];
  logic [7:0] gold [1024];
  logic [7:0] exp_hi = '0;
  int hi_lat = 0, lat_cnt = 0, hi_updates = 0, widx = 0;
  int cur_seed = 0;
  logic [15:0] cur_start = '0;
  logic ack_d;

  assign data_in = mem[{exp_hi[1:0], addr_lo}];
  assign wr_data = pat(cur_seed, widx);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d <= 1'b1; busack_n <= 1'b1; hi_done <= 1'b0; lat_cnt <= 0;
    end else begin
      ack_d <= busrq_n; busack_n <= ack_d;
      hi_done <= 1'b0;
      if (start) hi_updates <= 0;
      if (hi_req && !hi_done) begin
        if (lat_cnt >= hi_lat) begin
          hi_done <= 1'b1; exp_hi <= hi_byte; hi_updates <= hi_updates + 1; lat_cnt <= 0;
        end else lat_cnt <= lat_cnt + 1;
      end
      if (start) widx <= 0;
      else if (wr_valid && wr_ready) widx <= widx + 1;
      if (!mreq_n && !wr_n) mem[{exp_hi[1:0], addr_lo}] <= data_out;
    end
  end

  int acc_idx = 0, rd_idx = 0, slen = 0;
  bit rq_seen = 0, prev_mreq = 1, prev_doe = 0, cur_wr = 0;
  always @(negedge clk) if (rst_n) begin
    logic [15:0] a;
    if (start) begin acc_idx = 0; rd_idx = 0; slen = 0; rq_seen = 0; end
    if (!busrq_n) rq_seen = 1;
    if (!mreq_n) begin
      slen++;
      if (prev_mreq) begin
        a = 16'(cur_start + acc_idx);
        chk({exp_hi, addr_lo} == a, "R4 access address", int'({exp_hi, addr_lo}), int'(a));
        chk(!busack_n && !busrq_n, "R2 strobe while bus owned", int'(busack_n), 0);
        chk(!hi_req, "R3 no access during high-byte load", int'(hi_req), 0);
        if (cur_wr) begin
          chk(prev_doe, "R5 data driven before strobe", int'(prev_doe), 1);
          chk(data_out == pat(cur_seed, acc_idx), "R5 write byte order", int'(data_out), int'(pat(cur_seed, acc_idx)));
        end
        acc_idx++;
      end
    end else if (!prev_mreq) begin
      chk(slen == SW, "R5 strobe width", slen, SW);
      slen = 0;
    end
    if (rd_valid) begin
      a = 16'(cur_start + rd_idx);
      chk(rd_data == gold[a[9:0]], "R6 read byte", int'(rd_data), int'(gold[a[9:0]]));
      rd_idx++;
    end
    prev_mreq = mreq_n;
    prev_doe = data_oe;
  end

  task automatic xfer(int st_a, int len, bit wr, int seed, int lat);
    int pages;
    logic [15:0] a;
    cur_start = 16'(st_a); cur_wr = wr; cur_seed = seed; hi_lat = lat;
    cfg_addr = 16'(st_a); cfg_len = LEN_W'(len); cfg_write = wr;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (!done) @(negedge clk);
    chk(busrq_n && !bus_oe && !data_oe, "R8 released and floated", int'(bus_oe), 0);
    if (len == 0) begin
      chk(!rq_seen, "R1 no bus request for zero length", int'(rq_seen), 0);
      chk(acc_idx == 0 && hi_updates == 0, "R1 no activity", acc_idx, 0);
    end else begin
      pages = ((st_a + len - 1) >> 8) - (st_a >> 8) + 1;
      chk(hi_updates == pages, "R3 high-byte updates", hi_updates, pages);
      chk(acc_idx == len, "R4 access count", acc_idx, len);
      if (wr) begin
        for (int k = 0; k < len; k++) begin
          a = 16'(st_a + k);
          gold[a[9:0]] = pat(seed, k);
        end
        for (int k = 0; k < len; k++) begin
          a = 16'(st_a + k);
          chk(mem[a[9:0]] == gold[a[9:0]], "R5 memory content", int'(mem[a[9:0]]), int'(gold[a[9:0]]));
        end
      end else chk(rd_idx == len, "R6 read pulses", rd_idx, len);
    end
    repeat (2) @(negedge clk);
    chk(done, "R8 done held", int'(done), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'(i * 5 + 1); gold[i] = 8'(i * 5 + 1); end
    repeat (3) @(negedge clk);
    chk(busrq_n && mreq_n && rd_n && wr_n, "R9 reset strobes high", int'({busrq_n, mreq_n, rd_n, wr_n}), 15);
    chk(!bus_oe && !data_oe && !hi_req && !busy && !done, "R9 reset enables low", int'({bus_oe, data_oe, hi_req, busy, done}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    xfer(16'h0123, 0, 1, 1, 0);
    xfer(16'h00FB, 5, 0, 2, 1);
    for (int lat = 0; lat < 3; lat++)
      for (int off = 0; off < 5; off++)
        for (int len = 1; len <= 6; len++) begin
          xfer(16'h01FC + off, len, 1, lat * 40 + off * 6 + len, lat);
          xfer(16'h01FC + off, len, 0, 0, 2 - lat);
        end
    xfer(16'h01F0, 300, 1, 9, 2);
    xfer(16'h01F0, 300, 0, 0, 0);
    xfer(16'h03FF, 1, 1, 77, 4);
    xfer(16'h03FF, 1, 0, 0, 0);
    finish_run();
  end
endmodule